// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Port

This block is an eight-pin general-purpose I/O port reached through a small 16-bit register bus. Pins are switched between input and output four at a time, in two groups. Each pin's level passes through a two-flop synchronizer before software can read it or the edge logic can see it. Output pins keep feeding their driven level back through the pad, so the interrupt logic treats them like inputs.

Each pin has its own edge choice (rising or falling) and its own interrupt enable. When an enabled pin shows the chosen edge, a sticky pending flag is set. Software reads the pending flags and clears them by writing ones. The block raises a single interrupt request whenever a pending flag is set on a pin whose enable is also set.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads 0, `pin_o` and `pin_oe_o` are 0 and `irq_o` is low.
- R2: Register 1 holds direction. Bit 0 set makes pins 0..3 outputs and bit 1 set makes pins 4..7 outputs. `pin_oe_o` shows this for all four pins of each group at once. The register reads back in bits [1:0].
- R3: A write to register 0 sets `pin_o` from wdata[7:0]. A read of register 0 returns the pin levels in bits [7:0], two clock edges after they are sampled on `pin_i`.
- R4: Register 2 bit k selects the interrupt edge of pin k: 0 for rising, 1 for falling.
- R5: Register 3 holds the interrupt enables: pin k uses bit 8+k. Bits [7:0] are ignored on write and read as 0.
- R6: A selected edge on an enabled pin sets pending bit k at the third rising clock edge after the pin changes. A pin whose enable is clear never sets its pending bit.
- R7: Register 4 returns the pending flags in bits [7:0]. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: When a clear and a new edge land on the same pin in the same cycle, the pending bit stays set.
- R9: `irq_o` is high exactly when some pending bit is set and its enable is set. Disabling a pin masks its pending flag without clearing it.
- R10: A pin set as an output raises an edge interrupt from its own driven level, which returns on `pin_i`.
- R11: Addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Output levels to the pads |
| pin_oe_o | output | 8 | Output enable per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check on every cycle that each direction group's enables move as one, that a detected edge always leaves its pending bit set, and that a pending bit rises only after a detected edge. They also check that a clear with no competing edge empties the bit and that the request stays low while no enable is set. Only the bench scenarios can show the exact three-edge latency, the choice between rising and falling edges, the feedback path from an output pin, the same-cycle set-over-clear race at the ports, and that unmapped addresses and the low byte of the enable register have no effect. A behavioural model compares outputs and read data every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_EDGE = 3'd2,
    REG_IEN  = 3'd3,
    REG_PEND = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_sel_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    logic rise, fall;
    assign rise     = lvl_i[k] & ~prev_q[k];
    assign fall     = ~lvl_i[k] & prev_q[k];
    assign hit_o[k] = en_i[k] & (fall_sel_i[k] ? fall : rise);

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[k] <= 1'b0;
      else if (hit_o[k]) pend_q[k] <= 1'b1;
      else if (clr_i[k]) pend_q[k] <= 1'b0;
    end

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[k] |=> pend_q[k]);
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !hit_o[k]) |=> !pend_q[k]);
    a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[k]) |-> $past(hit_o[k]));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned GS = 4,
  localparam int unsigned NG  = W / GS,
  localparam int unsigned IEN_LSB = DATA_W - W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [W-1:0]      lvl_i,
  input  logic [W-1:0]      pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      fall_sel_o,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      clr_o
);
  logic [W-1:0]  out_q, fall_q, en_q;
  logic [NG-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      fall_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_DATA: out_q  <= wdata_i[W-1:0];
        REG_DIR:  dir_q  <= wdata_i[NG-1:0];
        REG_EDGE: fall_q <= wdata_i[W-1:0];
        REG_IEN:  en_q   <= wdata_i[IEN_LSB +: W];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == REG_PEND) ? wdata_i[W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DATA: rdata_o[W-1:0]        = lvl_i;
      REG_DIR:  rdata_o[NG-1:0]       = dir_q;
      REG_EDGE: rdata_o[W-1:0]        = fall_q;
      REG_IEN:  rdata_o[IEN_LSB +: W] = en_q;
      REG_PEND: rdata_o[W-1:0]        = pend_i;
      default: ;
    endcase
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign oe_o[g*GS +: GS] = {GS{dir_q[g]}};
    a_r2_group_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_o[g*GS +: GS] == '0) || (oe_o[g*GS +: GS] == '1));
  end

  assign out_o      = out_q;
  assign fall_sel_o = fall_q;
  assign en_o       = en_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS     = 8,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl, fall_sel, en, clr, hit, pend;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  gpio_edge_det #(.W(N_PINS)) u_det (
    .clk_i, .rst_ni, .lvl_i(lvl), .fall_sel_i(fall_sel), .en_i(en),
    .clr_i(clr), .hit_o(hit), .pend_o(pend)
  );

  gpio_regs #(.W(N_PINS), .GS(GROUP_SIZE)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .lvl_i(lvl), .pend_i(pend),
    .rdata_o, .out_o(pin_o), .oe_o(pin_oe_o), .fall_sel_o(fall_sel),
    .en_o(en), .clr_o(clr)
  );

  assign irq_o = |(pend & en);

  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  a_r9_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic [7:0]  ext = '0;
  logic [7:0]  pin_i, pin_o, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext);

  gpio_edge_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] hist[$];
  logic [7:0] m_out, m_fall, m_en, m_pend;
  logic [1:0] m_dir;

  function automatic logic [7:0] m_oe();
    return {{4{m_dir[1]}}, {4{m_dir[0]}}};
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, hist[1]};
      3'd1: return {14'h0, m_dir};
      3'd2: return {8'h00, m_fall};
      3'd3: return {m_en, 8'h00};
      3'd4: return {8'h00, m_pend};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{8'h00, 8'h00, 8'h00};
      m_out = '0; m_fall = '0; m_en = '0; m_pend = '0; m_dir = '0;
    end else begin
      logic [7:0] cur, old, hitv, pinv;
      cur  = hist[1];
      old  = hist[2];
      hitv = m_en & ((m_fall & old & ~cur) | (~m_fall & cur & ~old));
      pinv = (m_oe() & m_out) | (~m_oe() & ext);
      if (we && addr == 3'd4) m_pend = m_pend & ~wdata[7:0];
      m_pend = m_pend | hitv;
      if (we) begin
        case (addr)
          3'd0: m_out  = wdata[7:0];
          3'd1: m_dir  = wdata[1:0];
          3'd2: m_fall = wdata[7:0];
          3'd3: m_en   = wdata[15:8];
          default: ;
        endcase
      end
      hist.push_front(pinv);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 irq", {15'h0, irq}, {15'h0, |(m_pend & m_en)});
      chk("R3 pin_o", {8'h0, pin_o}, {8'h0, m_out});
      chk("R2 pin_oe", {8'h0, pin_oe}, {8'h0, m_oe()});
      chk("R11 rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a[2:0], "R1 reset read", 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 oe", {8'h0, pin_oe}, 16'h0);

    // R3 input readback latency
    ext = 8'hA5;
    wait_n(1); rd(3'd0, "R3 sync 1 edge", 16'h0000);
    wait_n(1); rd(3'd0, "R3 sync 2 edges", 16'h00A5);
    ext = 8'h00; wait_n(4);

    // R5 enable mapping, low byte ignored
    wr(3'd3, 16'h04FF);
    rd(3'd3, "R5 ien readback", 16'h0400);

    // R6 rising edge on pin 2, three-edge latency
    ext[2] = 1'b1;
    wait_n(1); chk("R6 lat 1", {15'h0, irq}, 16'h0);
    wait_n(1); chk("R6 lat 2", {15'h0, irq}, 16'h0);
    wait_n(1); chk("R6 lat 3", {15'h0, irq}, 16'h1);
    rd(3'd4, "R6 pend", 16'h0004);

    // R7 write zero no effect, write one clears
    wr(3'd4, 16'h00FB);
    rd(3'd4, "R7 zero keeps", 16'h0004);
    wr(3'd4, 16'h0004);
    rd(3'd4, "R7 clear", 16'h0000);
    chk("R7 irq low", {15'h0, irq}, 16'h0);

    // R6 disabled pin never sets
    ext[6] = 1'b1; wait_n(5);
    rd(3'd4, "R6 disabled", 16'h0000);

    // R4 falling edge on pin 5
    wr(3'd2, 16'h0020);
    wr(3'd3, 16'h2000);
    ext[5] = 1'b1; wait_n(5);
    rd(3'd4, "R4 rise ignored", 16'h0000);
    ext[5] = 1'b0; wait_n(4);
    rd(3'd4, "R4 falling", 16'h0020);

    // R9 masking keeps pending
    wr(3'd3, 16'h0000);
    chk("R9 masked", {15'h0, irq}, 16'h0);
    rd(3'd4, "R9 pend kept", 16'h0020);
    wr(3'd3, 16'h2000);
    chk("R9 unmasked", {15'h0, irq}, 16'h1);
    wr(3'd4, 16'h0020);

    // R8 same-cycle set and clear on pin 3
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0800);
    ext[3] = 1'b1; wait_n(4);
    rd(3'd4, "R8 first edge", 16'h0008);
    ext[3] = 1'b0; wait_n(4);
    ext[3] = 1'b1;
    wait_n(2);
    wr(3'd4, 16'h0008);
    rd(3'd4, "R8 set wins", 16'h0008);
    wr(3'd4, 16'h0008);
    rd(3'd4, "R8 then clear", 16'h0000);

    // R2 group direction and R10 output feedback on pin 0
    ext = 8'h00; wait_n(4);
    wr(3'd1, 16'h0001);
    chk("R2 low group", {8'h0, pin_oe}, 16'h000F);
    wr(3'd1, 16'h0002);
    chk("R2 high group", {8'h0, pin_oe}, 16'h00F0);
    wr(3'd1, 16'h0001);
    wr(3'd3, 16'h0100);
    wr(3'd0, 16'h0001);
    wait_n(3);
    rd(3'd4, "R10 feedback", 16'h0001);
    chk("R10 irq", {15'h0, irq}, 16'h1);
    rd(3'd0, "R3 loop level", 16'h0001);
    wr(3'd4, 16'h0001);

    // R11 unmapped writes have no effect
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd7, "R11 unmapped read", 16'h0000);
    rd(3'd1, "R11 dir kept", 16'h0001);
    rd(3'd2, "R11 edge kept", 16'h0000);
    rd(3'd3, "R11 ien kept", 16'h0100);
    chk("R11 pin_o kept", {8'h0, pin_o}, 16'h0001);

    wait_n(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule